// File: doc/BRIEF.md
# Radio-side SPI command decoder

This block is the slave end of the command link between a host and a radio. The host frames each command with an active-low chip select and clocks bytes in SPI mode 0, most significant bit first. The first byte of every frame is an opcode. The bytes that follow are arguments, write data or dummy bytes that clock response data out on MISO.

The block serves several stores. One is a byte-wide register window reached through a 16-bit address. Another is a 256-byte packet buffer that transmit and receive share, reached through an 8-bit offset. It also holds the transmit and receive base addresses, a receive status (length and start pointer) that the modem side loads, and a 16-bit interrupt flag word. After each complete command it raises a busy output for a fixed number of clocks. SCK, MOSI and chip select are sampled in the system clock domain. SCK must therefore stay high and low for at least eight system clocks each.

Top module: `radio_spi_slave`

## Requirements
- R1: After reset, busy, miso, tx_base and rx_base are all 0, and every register, buffer byte and interrupt flag reads as 0x00.
- R2: Opcode 0x0D is followed by a 16-bit address sent high byte first, then data bytes stored at successive addresses. Opcode 0x1D is followed by the same address form. The byte after the address returns the status byte, and each later byte returns the register at the address, then the next address, and so on. The register storage holds 2^REG_AW bytes, indexed by the low REG_AW address bits, so addresses that differ only above those bits reach the same byte.
- R3: Opcode 0x0E is followed by an offset byte, then data bytes stored at the offset and successive positions, with positions wrapping modulo 256.
- R4: Opcode 0x1E is followed by an offset byte. The next byte returns the status byte, and each later byte returns the buffer from the offset onward, wrapping modulo 256.
- R5: Opcode 0x8F takes two bytes: the first appears on tx_base and the second on rx_base.
- R6: After opcode 0x13, the next three bytes return the status byte, the receive length and the receive start pointer. A one-clock rx_done pulse loads the length from rx_len and the start pointer from the current rx_base.
- R7: Each bit of irq_set that is high in a clock sets the matching interrupt flag. After opcode 0x12, the next three bytes return the status byte, flag bits 15..8 and flag bits 7..0.
- R8: Opcode 0x02 takes a 16-bit mask, high byte first, and clears every flag whose mask bit is 1. A set in the same clock wins.
- R9: Opcode 0x89 takes one argument byte and stores it with bit 7 forced to 0 at register address CAL_ADDR (default 0x0989), where 0x1D reads it back.
- R10: When chip select rises after a frame of at least one complete byte, busy goes high for exactly BUSY_CYCLES clocks. A frame with no complete byte leaves busy low.
- R11: Any other opcode consumes its bytes, returns 0x00 on every byte and changes no register, buffer byte, base address or flag.
- R12: The status byte is 0x01 when any interrupt flag is set and 0x00 otherwise. MISO returns 0x00 during the opcode byte of every frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Frame select, active low |
| sck | input | 1 | Serial clock, idle low |
| mosi | input | 1 | Serial data from host |
| miso | output | 1 | Serial data to host |
| busy | output | 1 | High while a finished command completes |
| irq_set | input | 16 | Per-flag set pulses from the modem side |
| rx_done | input | 1 | Pulse: a received packet is complete |
| rx_len | input | 8 | Length loaded on rx_done |
| tx_base | output | 8 | Transmit base address in the shared buffer |
| rx_base | output | 8 | Receive base address in the shared buffer |

## Verification
Random buffer writes use random offsets and lengths, and each is read back against a model of the buffer. These runs separate correct offset stepping from lost or misplaced bytes, and the offsets near 0xFF expose a missing modulo-256 wrap. Random register writes to random 16-bit addresses, read back through the register opcode, separate auto-increment and low-bit indexing from faults in address assembly. Directed frames cover the rest: the calibrate argument 0xFF, flag set and mask patterns that leave some flags standing, an unknown opcode followed by read-back of the stores, and an empty frame. They separate the reserved-bit mask, selective clearing, the absence of side effects and the rule that a frame needs a byte before busy starts.

// File: rtl/radio_spi_pkg.sv
package radio_spi_pkg;
   localparam logic [7:0] OP_REG_WR  = 8'h0D;
   localparam logic [7:0] OP_REG_RD  = 8'h1D;
   localparam logic [7:0] OP_BUF_WR  = 8'h0E;
   localparam logic [7:0] OP_BUF_RD  = 8'h1E;
   localparam logic [7:0] OP_BASES   = 8'h8F;
   localparam logic [7:0] OP_RX_STAT = 8'h13;
   localparam logic [7:0] OP_IRQ_GET = 8'h12;
   localparam logic [7:0] OP_IRQ_CLR = 8'h02;
   localparam logic [7:0] OP_CAL     = 8'h89;

   // status byte: bit 0 flags any pending interrupt
   function automatic logic [7:0] status_of(input logic [15:0] flags);
      return {7'd0, |flags};
   endfunction
endpackage

// File: rtl/rsd_spi_link.sv
module rsd_spi_link #(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cs_n,
   input  logic       sck,
   input  logic       mosi,
   input  logic [7:0] tx_byte,
   output logic       miso,
   output logic       byte_valid,
   output logic [7:0] rx_byte,
   output logic       frame_start,
   output logic       frame_end
);
   initial assert (SYNC_STAGES >= 2) else $error("SYNC_STAGES must be at least 2");

   logic [SYNC_STAGES-1:0][2:0] sy;
   logic cs_s, sck_s, mosi_s, cs_d, sck_d;
   logic sck_rise, sck_fall;
   logic [2:0] bitcnt;
   logic [6:0] rx_sh;
   logic [7:0] tx_sh;
   logic       load_pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < SYNC_STAGES; i++) sy[i] <= 3'b100;
         cs_d  <= 1'b1;
         sck_d <= 1'b0;
      end else begin
         sy[0] <= {cs_n, sck, mosi};
         for (int i = 1; i < SYNC_STAGES; i++) sy[i] <= sy[i-1];
         cs_d  <= cs_s;
         sck_d <= sck_s;
      end
   end

   assign cs_s        = sy[SYNC_STAGES-1][2];
   assign sck_s       = sy[SYNC_STAGES-1][1];
   assign mosi_s      = sy[SYNC_STAGES-1][0];
   assign sck_rise    = sck_s & ~sck_d;
   assign sck_fall    = ~sck_s & sck_d;
   assign frame_start = cs_d & ~cs_s;
   assign frame_end   = ~cs_d & cs_s;
   assign miso        = tx_sh[7];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bitcnt     <= '0;
         rx_sh      <= '0;
         tx_sh      <= '0;
         load_pend  <= 1'b0;
         byte_valid <= 1'b0;
         rx_byte    <= '0;
      end else begin
         byte_valid <= 1'b0;
         if (cs_s) begin
            bitcnt    <= '0;
            load_pend <= 1'b0;
            tx_sh     <= '0;
         end else begin
            if (sck_rise) begin
               rx_sh  <= {rx_sh[5:0], mosi_s};
               bitcnt <= bitcnt + 3'd1;
               if (bitcnt == 3'd7) begin
                  byte_valid <= 1'b1;
                  rx_byte    <= {rx_sh, mosi_s};
                  load_pend  <= 1'b1;
               end
            end
            if (sck_fall) begin
               if (load_pend) begin
                  tx_sh     <= tx_byte;
                  load_pend <= 1'b0;
               end else begin
                  tx_sh <= {tx_sh[6:0], 1'b0};
               end
            end
         end
      end
   end

   // R12
   opcode_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |-> (tx_sh == 8'h00));

   // R2
   byte_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      byte_valid |=> !byte_valid);
endmodule

// File: rtl/rsd_byte_ram.sv
module rsd_byte_ram #(
   parameter int AW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [7:0]    wdata,
   input  logic [AW-1:0] raddr,
   output logic [7:0]    rdata
);
   localparam int DEPTH = 1 << AW;
   initial assert (AW >= 1 && AW <= 12) else $error("AW out of range");

   logic [7:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
      end else if (we) begin
         mem[waddr] <= wdata;
      end
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/rsd_busy_timer.sv
module rsd_busy_timer #(
   parameter int CYCLES = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);
   initial assert (CYCLES >= 1) else $error("CYCLES must be at least 1");

   generate
      if (CYCLES == 1) begin : g_single
         logic busy_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) busy_q <= 1'b0;
            else        busy_q <= start;
         end
         assign busy = busy_q;
      end else begin : g_count
         localparam int CW = $clog2(CYCLES + 1);
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            cnt <= '0;
            else if (start)        cnt <= CW'(CYCLES);
            else if (cnt != '0)    cnt <= cnt - 1'b1;
         end
         assign busy = (cnt != '0);
      end
   endgenerate

   // R10
   busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> busy);

   // R10
   busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));
endmodule

// File: rtl/rsd_cmd_decoder.sv
module rsd_cmd_decoder
   import radio_spi_pkg::*;
#(
   parameter int          REG_AW   = 8,
   parameter logic [15:0] CAL_ADDR = 16'h0989
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_start,
   input  logic              byte_valid,
   input  logic [7:0]        rx_byte,
   output logic [7:0]        tx_byte,
   output logic              cmd_seen,
   input  logic [15:0]       irq_set,
   input  logic              rx_done,
   input  logic [7:0]        rx_len,
   output logic [7:0]        tx_base,
   output logic [7:0]        rx_base,
   output logic              reg_we,
   output logic [REG_AW-1:0] reg_waddr,
   output logic [7:0]        reg_wdata,
   output logic [REG_AW-1:0] reg_raddr,
   input  logic [7:0]        reg_rdata,
   output logic              buf_we,
   output logic [7:0]        buf_waddr,
   output logic [7:0]        buf_wdata,
   output logic [7:0]        buf_raddr,
   input  logic [7:0]        buf_rdata
);
   initial assert (REG_AW >= 1 && REG_AW <= 12) else $error("REG_AW out of range");
   localparam logic [REG_AW-1:0] CAL_IDX = CAL_ADDR[REG_AW-1:0];

   logic [7:0]  op;
   logic [1:0]  idx;
   logic [15:0] ptr;
   logic [7:0]  hi;
   logic [15:0] flags;
   logic [7:0]  rx_len_q, rx_ptr_q;
   logic        clr_now;
   logic [15:0] clr_mask;
   logic [7:0]  stat;

   assign stat      = status_of(flags);
   assign reg_raddr = ptr[REG_AW-1:0];
   assign buf_raddr = ptr[7:0];
   assign clr_now   = byte_valid && !frame_start && idx == 2'd2 && op == OP_IRQ_CLR;
   assign clr_mask  = clr_now ? {hi, rx_byte} : 16'h0000;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags    <= '0;
         rx_len_q <= '0;
         rx_ptr_q <= '0;
      end else begin
         flags <= (flags & ~clr_mask) | irq_set;
         if (rx_done) begin
            rx_len_q <= rx_len;
            rx_ptr_q <= rx_base;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op        <= '0;
         idx       <= '0;
         ptr       <= '0;
         hi        <= '0;
         tx_byte   <= '0;
         cmd_seen  <= 1'b0;
         tx_base   <= '0;
         rx_base   <= '0;
         reg_we    <= 1'b0;
         reg_waddr <= '0;
         reg_wdata <= '0;
         buf_we    <= 1'b0;
         buf_waddr <= '0;
         buf_wdata <= '0;
      end else begin
         reg_we <= 1'b0;
         buf_we <= 1'b0;
         if (frame_start) begin
            idx      <= '0;
            cmd_seen <= 1'b0;
            tx_byte  <= 8'h00;
         end else if (byte_valid) begin
            if (idx != 2'd3) idx <= idx + 2'd1;
            if (idx == 2'd0) begin
               op       <= rx_byte;
               cmd_seen <= 1'b1;
               tx_byte  <= (rx_byte == OP_RX_STAT || rx_byte == OP_IRQ_GET) ? stat : 8'h00;
            end else begin
               tx_byte <= 8'h00;
               case (op)
                  OP_REG_WR: begin
                     if (idx == 2'd1) hi <= rx_byte;
                     else if (idx == 2'd2) ptr <= {hi, rx_byte};
                     else begin
                        reg_we    <= 1'b1;
                        reg_waddr <= ptr[REG_AW-1:0];
                        reg_wdata <= rx_byte;
                        ptr       <= ptr + 16'd1;
                     end
                  end
                  OP_REG_RD: begin
                     if (idx == 2'd1) hi <= rx_byte;
                     else if (idx == 2'd2) begin
                        ptr     <= {hi, rx_byte};
                        tx_byte <= stat;
                     end else begin
                        tx_byte <= reg_rdata;
                        ptr     <= ptr + 16'd1;
                     end
                  end
                  OP_BUF_WR: begin
                     if (idx == 2'd1) ptr <= {8'h00, rx_byte};
                     else begin
                        buf_we    <= 1'b1;
                        buf_waddr <= ptr[7:0];
                        buf_wdata <= rx_byte;
                        ptr       <= {8'h00, ptr[7:0] + 8'd1};
                     end
                  end
                  OP_BUF_RD: begin
                     if (idx == 2'd1) begin
                        ptr     <= {8'h00, rx_byte};
                        tx_byte <= stat;
                     end else begin
                        tx_byte <= buf_rdata;
                        ptr     <= {8'h00, ptr[7:0] + 8'd1};
                     end
                  end
                  OP_BASES: begin
                     if (idx == 2'd1) tx_base <= rx_byte;
                     else if (idx == 2'd2) rx_base <= rx_byte;
                  end
                  OP_RX_STAT: begin
                     if (idx == 2'd1) tx_byte <= rx_len_q;
                     else if (idx == 2'd2) tx_byte <= rx_ptr_q;
                  end
                  OP_IRQ_GET: begin
                     if (idx == 2'd1) tx_byte <= flags[15:8];
                     else if (idx == 2'd2) tx_byte <= flags[7:0];
                  end
                  OP_IRQ_CLR: begin
                     if (idx == 2'd1) hi <= rx_byte;
                  end
                  OP_CAL: begin
                     if (idx == 2'd1) begin
                        reg_we    <= 1'b1;
                        reg_waddr <= CAL_IDX;
                        reg_wdata <= rx_byte & 8'h7F;
                     end
                  end
                  default: tx_byte <= 8'h00;
               endcase
            end
         end
      end
   end

   // R3
   buf_ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      buf_we |-> (ptr[7:0] == buf_waddr + 8'd1));

   // R2
   reg_ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && op == OP_REG_WR) |-> (ptr[REG_AW-1:0] == REG_AW'(reg_waddr + 1'b1)));

   // R9
   cal_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && op == OP_CAL) |-> (!reg_wdata[7] && reg_waddr == CAL_IDX));

   // R8
   irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_now && irq_set == 16'h0000) |=> ((flags & $past(clr_mask)) == 16'h0000));
endmodule

// File: rtl/radio_spi_slave.sv
module radio_spi_slave #(
   parameter int          REG_AW      = 8,
   parameter int          BUSY_CYCLES = 16,
   parameter int          SYNC_STAGES = 2,
   parameter logic [15:0] CAL_ADDR    = 16'h0989
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cs_n,
   input  logic        sck,
   input  logic        mosi,
   output logic        miso,
   output logic        busy,
   input  logic [15:0] irq_set,
   input  logic        rx_done,
   input  logic [7:0]  rx_len,
   output logic [7:0]  tx_base,
   output logic [7:0]  rx_base
);
   logic              byte_valid, frame_start, frame_end, cmd_seen;
   logic [7:0]        rx_byte, tx_byte;
   logic              reg_we, buf_we;
   logic [REG_AW-1:0] reg_waddr, reg_raddr;
   logic [7:0]        reg_wdata, reg_rdata;
   logic [7:0]        buf_waddr, buf_raddr, buf_wdata, buf_rdata;

   rsd_spi_link #(.SYNC_STAGES(SYNC_STAGES)) u_link (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
      .tx_byte(tx_byte), .miso(miso), .byte_valid(byte_valid),
      .rx_byte(rx_byte), .frame_start(frame_start), .frame_end(frame_end));

   rsd_cmd_decoder #(.REG_AW(REG_AW), .CAL_ADDR(CAL_ADDR)) u_dec (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
      .byte_valid(byte_valid), .rx_byte(rx_byte), .tx_byte(tx_byte),
      .cmd_seen(cmd_seen), .irq_set(irq_set), .rx_done(rx_done),
      .rx_len(rx_len), .tx_base(tx_base), .rx_base(rx_base),
      .reg_we(reg_we), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
      .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
      .buf_we(buf_we), .buf_waddr(buf_waddr), .buf_wdata(buf_wdata),
      .buf_raddr(buf_raddr), .buf_rdata(buf_rdata));

   rsd_byte_ram #(.AW(REG_AW)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .waddr(reg_waddr),
      .wdata(reg_wdata), .raddr(reg_raddr), .rdata(reg_rdata));

   rsd_byte_ram #(.AW(8)) u_buf (
      .clk(clk), .rst_n(rst_n), .we(buf_we), .waddr(buf_waddr),
      .wdata(buf_wdata), .raddr(buf_raddr), .rdata(buf_rdata));

   rsd_busy_timer #(.CYCLES(BUSY_CYCLES)) u_busy (
      .clk(clk), .rst_n(rst_n), .start(frame_end & cmd_seen), .busy(busy));
endmodule

// File: tb/tb_radio_spi_slave.sv
module tb_radio_spi_slave;
   localparam int BUSY = 16;
   localparam int HALF = 32;

   logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, mosi = 1'b0;
   logic miso, busy, rx_done = 1'b0;
   logic [15:0] irq_set = 16'h0;
   logic [7:0]  rx_len = 8'h0, tx_base, rx_base;

   radio_spi_slave #(.BUSY_CYCLES(BUSY)) dut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
      .miso(miso), .busy(busy), .irq_set(irq_set), .rx_done(rx_done),
      .rx_len(rx_len), .tx_base(tx_base), .rx_base(rx_base));

   always #2 clk = ~clk;

   int nchk = 0, nfail = 0, busy_cnt = 0;
   bit finished = 1'b0;
   logic [7:0] tb_tx [0:15];
   logic [7:0] tb_rx [0:15];
   logic [7:0] m_buf [0:255];
   logic [7:0] m_reg [0:255];
   logic [15:0] m_flags = 16'h0;

   always @(negedge clk) if (busy) busy_cnt++;

   function automatic logic [7:0] exp_status();
      return {7'd0, |m_flags};
   endfunction

   task automatic check(input string req, input string what, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic frame(input int n);
      cs_n = 1'b0;
      #HALF;
      for (int k = 0; k < n; k++) begin
         for (int b = 7; b >= 0; b--) begin
            mosi = tb_tx[k][b];
            #HALF;
            tb_rx[k][b] = miso;
            sck = 1'b1;
            #HALF;
            sck = 1'b0;
         end
      end
      #HALF;
      cs_n = 1'b1;
      #((BUSY + 12) * 4);
   endtask

   task automatic clear_tx();
      for (int k = 0; k < 16; k++) tb_tx[k] = 8'h00;
   endtask

   task automatic buf_check(input string req, input int off, input int len);
      clear_tx();
      tb_tx[0] = 8'h1E; tb_tx[1] = 8'(off);
      frame(len + 3);
      check(req, "buf rd status", tb_rx[2], exp_status());
      for (int i = 0; i < len; i++)
         check(req, "buf rd data", tb_rx[3+i], m_buf[(off+i)%256]);
   endtask

   task automatic reg_check(input string req, input int addr, input int len);
      clear_tx();
      tb_tx[0] = 8'h1D; tb_tx[1] = 8'(addr >> 8); tb_tx[2] = 8'(addr);
      frame(len + 4);
      check(req, "reg rd status", tb_rx[3], exp_status());
      for (int i = 0; i < len; i++)
         check(req, "reg rd data", tb_rx[4+i], m_reg[(addr+i)%256]);
   endtask

   initial begin
      #700000;
      if (!finished) begin
         nfail++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
         $finish;
      end
   end

   initial begin
      int off, len, addr;
      void'($urandom(32'd20240611));
      for (int i = 0; i < 256; i++) begin m_buf[i] = 8'h00; m_reg[i] = 8'h00; end
      #1;
      #40 rst_n = 1'b1;
      #40;
      // R1 reset state
      check("R1", "busy", busy, 0);
      check("R1", "miso", miso, 0);
      check("R1", "tx_base", tx_base, 0);
      check("R1", "rx_base", rx_base, 0);
      buf_check("R1", 0, 4);

      // R2 directed: pair of addresses in one frame, then read back
      clear_tx();
      tb_tx[0] = 8'h0D; tb_tx[1] = 8'h06; tb_tx[2] = 8'hCD; tb_tx[3] = 8'hAA; tb_tx[4] = 8'h55;
      frame(5);
      m_reg[8'hCD] = 8'hAA; m_reg[8'hCE] = 8'h55;
      reg_check("R2", 16'h06CD, 2);
      reg_check("R2", 16'h00CD, 2);   // R2 low-bit indexing

      // R10 busy length after a frame, and no busy for empty frame
      busy_cnt = 0;
      clear_tx(); tb_tx[0] = 8'hC0;
      frame(1);
      check("R10", "busy cycles", busy_cnt, BUSY);
      check("R12", "opcode byte reply", tb_rx[0], 0);
      busy_cnt = 0;
      frame(0);
      check("R10", "busy on empty frame", busy_cnt, 0);

      // R3 R4 random buffer traffic
      for (int t = 0; t < 20; t++) begin
         off = $urandom % 256; len = 1 + $urandom % 8;
         clear_tx();
         tb_tx[0] = 8'h0E; tb_tx[1] = 8'(off);
         for (int i = 0; i < len; i++) begin
            tb_tx[2+i] = 8'($urandom);
            m_buf[(off+i)%256] = tb_tx[2+i];
         end
         frame(len + 2);
         buf_check("R4", off, len);
      end
      // R3 wrap past the end
      clear_tx();
      tb_tx[0] = 8'h0E; tb_tx[1] = 8'hFE;
      tb_tx[2] = 8'h11; tb_tx[3] = 8'h22; tb_tx[4] = 8'h33; tb_tx[5] = 8'h44;
      frame(6);
      m_buf[254] = 8'h11; m_buf[255] = 8'h22; m_buf[0] = 8'h33; m_buf[1] = 8'h44;
      buf_check("R3", 254, 4);
      buf_check("R4", 0, 2);

      // R2 random register traffic
      for (int t = 0; t < 12; t++) begin
         addr = $urandom % 65536; len = 1 + $urandom % 6;
         clear_tx();
         tb_tx[0] = 8'h0D; tb_tx[1] = 8'(addr >> 8); tb_tx[2] = 8'(addr);
         for (int i = 0; i < len; i++) begin
            tb_tx[3+i] = 8'($urandom);
            m_reg[(addr+i)%256] = tb_tx[3+i];
         end
         frame(len + 3);
         reg_check("R2", addr, len);
      end

      // R5 base addresses
      clear_tx(); tb_tx[0] = 8'h8F; tb_tx[1] = 8'h12; tb_tx[2] = 8'h34;
      frame(3);
      check("R5", "tx_base", tx_base, 8'h12);
      check("R5", "rx_base", rx_base, 8'h34);

      // R6 receive status before and after rx_done
      clear_tx(); tb_tx[0] = 8'h13;
      frame(4);
      check("R6", "status", tb_rx[1], exp_status());
      check("R6", "len", tb_rx[2], 0);
      check("R6", "ptr", tb_rx[3], 0);
      rx_len = 8'h21; rx_done = 1'b1; #4 rx_done = 1'b0; #8;
      frame(4);
      check("R6", "len", tb_rx[2], 8'h21);
      check("R6", "ptr", tb_rx[3], 8'h34);

      // R7 interrupt flags
      irq_set = 16'h0281; #4 irq_set = 16'h0; #8;
      m_flags = 16'h0281;
      clear_tx(); tb_tx[0] = 8'h12;
      frame(4);
      check("R7", "status", tb_rx[1], 8'h01);
      check("R7", "flags hi", tb_rx[2], 8'h02);
      check("R7", "flags lo", tb_rx[3], 8'h81);
      buf_check("R12", 0, 1);

      // R8 selective clear, then full clear
      clear_tx(); tb_tx[0] = 8'h02; tb_tx[1] = 8'h00; tb_tx[2] = 8'h81;
      frame(3);
      m_flags = 16'h0200;
      clear_tx(); tb_tx[0] = 8'h12;
      frame(4);
      check("R8", "status", tb_rx[1], 8'h01);
      check("R8", "flags hi", tb_rx[2], 8'h02);
      check("R8", "flags lo", tb_rx[3], 8'h00);
      clear_tx(); tb_tx[0] = 8'h02; tb_tx[1] = 8'hFF; tb_tx[2] = 8'hFF;
      frame(3);
      m_flags = 16'h0;
      clear_tx(); tb_tx[0] = 8'h12;
      frame(4);
      check("R8", "status after full clear", tb_rx[1], 8'h00);
      check("R12", "status zero", tb_rx[1], 8'h00);

      // R9 calibrate argument masks bit 7
      clear_tx(); tb_tx[0] = 8'h89; tb_tx[1] = 8'hFF;
      frame(2);
      m_reg[8'h89] = 8'h7F;
      reg_check("R9", 16'h0989, 1);

      // R11 unknown opcode: zero replies, no side effects
      clear_tx();
      tb_tx[0] = 8'h55; tb_tx[1] = 8'h00; tb_tx[2] = 8'hAB; tb_tx[3] = 8'hCD; tb_tx[4] = 8'hEF;
      frame(5);
      for (int i = 0; i < 5; i++) check("R11", "reply", tb_rx[i], 0);
      buf_check("R11", 254, 4);
      reg_check("R11", 16'h06CD, 2);
      check("R11", "tx_base", tx_base, 8'h12);
      check("R11", "rx_base", rx_base, 8'h34);

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
      $finish;
   end
endmodule